// File: doc/BRIEF.md
# Bus Cycle Sequencer with Abort-and-Replay Backoff

This block runs the bus cycles of a bus master. An internal requester hands it one request at a time. A request is a single read, a single write, or a four-beat burst read. The block drives the address, the write flag, the address strobe and the write data, each with its own output enable. It also drives a bus-request line, and it samples the ready strobe and the read data that the system returns. One idle clock always separates two bus cycles.

System logic can force the master off the bus at any time through the backoff input. The block reacts on the clock after it samples backoff high. It drops every enable, abandons the cycle in progress and throws away any read beats already collected. While backoff is held, the block keeps bus request asserted as long as a request is waiting. When backoff is released, the abandoned cycle is issued again from its first beat, with the same address and type. A write that was backed off is therefore only delayed and never lost.

A read completes only when every one of its beats arrives within one uninterrupted attempt. The requester then receives the whole line in a single response pulse.

Top module: `retry_bus_master`

## Requirements
- R1: In every cycle that follows a rising edge at which `backoffIn` (active high) was sampled high, `busAddrOe`, `adsOe` and `busDataOe` are all low.
- R2: A completed read returns its line on `rspData`. Beat i sits at bits [i*DATA_W +: DATA_W], and every beat comes from the final, uninterrupted attempt. Lanes that no beat filled read zero, and a write's response data is all zero.
- R3: Every accepted request gets exactly one `rspValid` pulse, in the cycle right after the edge that accepts its last beat. An aborted attempt gives no pulse.
- R4: When `backoffIn` is sampled low after a cycle was aborted, the strobe (`adsOut` and `adsOe` both high) appears in the very next cycle, with the original `busAddr` and `busWrite`, and the beat count starts again at zero.
- R5: The strobe appears only after an accepted request or as a replay. It never appears earlier than the second cycle after the edge at which a bus cycle completed or was aborted.
- R6: Backoff may be held for hundreds of cycles. The bus stays floated for the whole hold, and the block has no way to end the hold itself.
- R7: `busReqOut` is high in every cycle in which the block owns the bus. While backed off, it equals (a request is pending or `reqValid` is high).
- R8: If backoff is sampled high at the end of a strobe cycle, `adsOut` stays high with `adsOe` low for the whole hold. In every other backed-off cycle, `adsOut` is low.
- R9: A write drives `busDataOe` high with `busWdata` equal to the request data in its strobe and data cycles. A write that is backed off is completed later, so the number of responses equals the number of accepted requests.
- R10: If backoff and `rdyIn` are both sampled high at the same edge, the beat is not taken and the cycle counts as aborted.
- R11: Synchronous active-high `rst` leaves all enables low, `busReqOut` low, `rspValid` low and `reqReady` high (with `backoffIn` low).
- R12: A burst read (`reqBurst`=1, `reqWrite`=0) takes four ready beats. A single read or a write takes one. `reqBurst` is ignored for writes, and a ready in the strobe cycle is not counted.
- R13: `reqReady` is high only while the sequencer is idle with `backoffIn` low. It is low whenever backoff is high or a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Requester presents a request |
| reqReady | output | 1 | Request taken at this edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBurst | input | 1 | 1 = four-beat burst read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspData | output | BURST_BEATS*DATA_W | Read line, beat 0 in the low lane |
| backoffIn | input | 1 | Backoff, active high |
| rdyIn | input | 1 | Ready strobe from the system |
| busDataIn | input | DATA_W | Read data from the bus |
| busAddr | output | ADDR_W | Address value |
| busWrite | output | 1 | Cycle type value |
| busAddrOe | output | 1 | Enable for address and type |
| adsOut | output | 1 | Address strobe level, active high |
| adsOe | output | 1 | Address strobe enable |
| busWdata | output | DATA_W | Write data value |
| busDataOe | output | 1 | Write data enable |
| busReqOut | output | 1 | Bus request |

## Verification
The bench aims backoff at the strobe cycle and at the last ready beat of a burst, and it holds backoff once for several hundred cycles. A design that resumed a burst instead of replaying it would return a line that mixes data from two attempts. The bench detects this because every beat's data encodes the attempt number. A design that let ready win over backoff would deliver a line early. A design that replayed too late, or squeezed out the idle clock, would misplace the strobe. If the design dropped the strobe level or the bus request during a hold, the level checks taken in each backed-off cycle would report it.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_GAP  = 3'd3,
    ST_BOFF = 3'd4
  } seqState_t;

  typedef struct packed {
    logic loadReq;   // capture a new request
    logic capBeat;   // take one ready beat
    logic clrBeats;  // abort: drop collected beats
    logic finish;    // last beat taken
  } seqStrobe_t;
endpackage

// File: rtl/rbm_ctrl.sv
module rbm_ctrl
  import rbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       backoffIn,
  input  logic       rdyIn,
  input  logic       curWrite,
  input  logic       lastBeat,
  output seqStrobe_t ctl,
  output logic       reqReady,
  output logic       busReqOut,
  output logic       adsOut,
  output logic       adsOe,
  output logic       addrOe,
  output logic       dataOe
);
  seqState_t state, nextState;
  logic      pendValid;
  logic      adsHeld;
  logic      onBus;

  always_comb begin
    nextState = state;
    ctl       = '0;
    if (backoffIn) begin
      nextState = ST_BOFF;
      if (state == ST_ADDR || state == ST_DATA) ctl.clrBeats = 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          nextState   = ST_ADDR;
          ctl.loadReq = 1'b1;
        end
        ST_ADDR: nextState = ST_DATA;
        ST_DATA: if (rdyIn) begin
          ctl.capBeat = 1'b1;
          if (lastBeat) begin
            ctl.finish = 1'b1;
            nextState  = ST_GAP;
          end
        end
        ST_GAP:  nextState = ST_IDLE;
        ST_BOFF: nextState = pendValid ? ST_ADDR : ST_IDLE;
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pendValid <= 1'b0;
      adsHeld   <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.loadReq)     pendValid <= 1'b1;
      else if (ctl.finish) pendValid <= 1'b0;
      if (backoffIn) adsHeld <= (state == ST_BOFF) ? adsHeld : (state == ST_ADDR);
      else           adsHeld <= 1'b0;
    end
  end

  assign onBus     = (state == ST_ADDR) || (state == ST_DATA);
  assign reqReady  = (state == ST_IDLE) && !backoffIn;
  assign adsOe     = (state == ST_ADDR);
  assign adsOut    = (state == ST_ADDR) || ((state == ST_BOFF) && adsHeld);
  assign addrOe    = onBus;
  assign dataOe    = onBus && curWrite;
  assign busReqOut = onBus || ((state == ST_BOFF) && (pendValid || reqValid));

  // R1
  float_on_boff_chk: assert property (@(posedge clk) disable iff (rst)
    $past(backoffIn) |-> (!addrOe && !adsOe && !dataOe));
  // R5
  idle_before_ads_chk: assert property (@(posedge clk) disable iff (rst)
    adsOe |-> ($past(state) == ST_IDLE || $past(state) == ST_BOFF));
  // R7
  hold_busreq_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(backoffIn) && pendValid) |-> busReqOut);
  // R8
  ads_float_level_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(backoffIn) && $past(state) == ST_ADDR) |-> (adsOut && !adsOe));
endmodule

// File: rtl/rbm_dpath.sv
module rbm_dpath
  import rbm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BURST_BEATS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  seqStrobe_t                    ctl,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic                          reqWrite,
  input  logic                          reqBurst,
  input  logic [DATA_W-1:0]             reqWdata,
  input  logic [DATA_W-1:0]             busDataIn,
  input  logic                          backoffIn,
  input  logic                          rdyIn,
  output logic [ADDR_W-1:0]             curAddr,
  output logic                          curWrite,
  output logic [DATA_W-1:0]             curWdata,
  output logic                          lastBeat,
  output logic                          rspValid,
  output logic [BURST_BEATS*DATA_W-1:0] rspData
);
  localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

  logic              burstQ;
  logic [BEAT_W-1:0] beatCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr  <= '0;
      curWrite <= 1'b0;
      curWdata <= '0;
      burstQ   <= 1'b0;
      beatCnt  <= '0;
      rspValid <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        curAddr  <= reqAddr;
        curWrite <= reqWrite;
        curWdata <= reqWdata;
        burstQ   <= reqBurst && !reqWrite;
      end
      if (ctl.loadReq || ctl.clrBeats || ctl.finish) beatCnt <= '0;
      else if (ctl.capBeat)                          beatCnt <= beatCnt + 1'b1;
      rspValid <= ctl.finish;
    end
  end

  assign lastBeat = burstQ ? (beatCnt == BEAT_W'(BURST_BEATS - 1)) : 1'b1;

  for (genvar g = 0; g < BURST_BEATS; g++) begin : g_lane
    logic [DATA_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (rst || ctl.loadReq || ctl.clrBeats)
        laneQ <= '0;
      else if (ctl.capBeat && !curWrite && beatCnt == BEAT_W'(g))
        laneQ <= busDataIn;
    end
    assign rspData[g*DATA_W +: DATA_W] = laneQ;
  end

  // R3
  no_rsp_after_abort_chk: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> !$past(backoffIn));
  // R10
  abort_clears_beats_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(backoffIn)) |-> (beatCnt == '0));
  // R12
  rsp_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> $past(rdyIn));
endmodule

// File: rtl/retry_bus_master.sv
module retry_bus_master
  import rbm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BURST_BEATS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic                          reqWrite,
  input  logic                          reqBurst,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  output logic                          rspValid,
  output logic [BURST_BEATS*DATA_W-1:0] rspData,
  input  logic                          backoffIn,
  input  logic                          rdyIn,
  input  logic [DATA_W-1:0]             busDataIn,
  output logic [ADDR_W-1:0]             busAddr,
  output logic                          busWrite,
  output logic                          busAddrOe,
  output logic                          adsOut,
  output logic                          adsOe,
  output logic [DATA_W-1:0]             busWdata,
  output logic                          busDataOe,
  output logic                          busReqOut
);
  seqStrobe_t ctl;
  logic       curWrite;
  logic       lastBeat;

  rbm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .backoffIn(backoffIn),
    .rdyIn(rdyIn), .curWrite(curWrite), .lastBeat(lastBeat), .ctl(ctl),
    .reqReady(reqReady), .busReqOut(busReqOut), .adsOut(adsOut),
    .adsOe(adsOe), .addrOe(busAddrOe), .dataOe(busDataOe)
  );

  rbm_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_BEATS(BURST_BEATS)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqBurst(reqBurst), .reqWdata(reqWdata), .busDataIn(busDataIn),
    .backoffIn(backoffIn), .rdyIn(rdyIn), .curAddr(busAddr),
    .curWrite(curWrite), .curWdata(busWdata), .lastBeat(lastBeat),
    .rspValid(rspValid), .rspData(rspData)
  );

  assign busWrite = curWrite;
endmodule

// File: tb/sim_retry_bus_master.sv
module sim_retry_bus_master;
  localparam int AW = 32, DW = 32, NB = 4, LW = NB * DW;
  localparam int LONG_HOLD = 300;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, reqValid = 1'b0, reqWrite = 1'b0, reqBurst = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0, busDataIn = '0;
  logic backoffIn = 1'b0, rdyIn = 1'b0;
  logic reqReady, rspValid, busWrite, busAddrOe, adsOut, adsOe, busDataOe, busReqOut;
  logic [LW-1:0] rspData;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busWdata;

  retry_bus_master #(.ADDR_W(AW), .DATA_W(DW), .BURST_BEATS(NB)) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBurst(reqBurst), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .backoffIn(backoffIn), .rdyIn(rdyIn), .busDataIn(busDataIn),
    .busAddr(busAddr), .busWrite(busWrite), .busAddrOe(busAddrOe),
    .adsOut(adsOut), .adsOe(adsOe), .busWdata(busWdata),
    .busDataOe(busDataOe), .busReqOut(busReqOut)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] beatData(input logic [AW-1:0] a, input int b, input int att);
    return a ^ (32'(att) * 32'h9E3779B1) ^ (32'(b + 1) * 32'h01000193);
  endfunction

  // bench model of the bus
  bit outstanding = 0, active = 0, firstCyc = 0, boffLast = 0, boffPrev = 0;
  bit heldAds = 0, expRsp = 0, accLast = 0, oWrite = 0, oBurst = 0;
  bit armLong = 0, longRun = 0, noNew = 0, quiet = 0;
  int beatIdx = 0, attempt = 0, sinceEnd = 100, nBeats = 1;
  int holdLen = 0, forceLen = 0, accepts = 0, rsps = 0;
  int hitAds = 0, hitLast = 0, hitLong = 0;
  logic [AW-1:0] oAddr = '0;
  logic [DW-1:0] oWdata = '0;
  logic [LW-1:0] expLine = '0, rspLine = '0;

  task automatic step();
    bit bo, rd, acc, adsNow, expAds;
    logic [DW-1:0] d;
    // drive section (at a falling edge)
    if (accLast) reqValid = 1'b0;
    bo = 1'b0;
    if (forceLen > 0) begin bo = 1'b1; forceLen--; end
    else if (armLong && active && !firstCyc) begin
      bo = 1'b1; forceLen = LONG_HOLD - 1; armLong = 0; hitLong++; longRun = 1;
    end
    else if (quiet) bo = 1'b0;
    else if (holdLen > 0) begin bo = 1'b1; holdLen--; end
    else if (active && firstCyc && $urandom % 5 == 0) begin
      bo = 1'b1; holdLen = $urandom % 4; hitAds++;
    end
    else if ($urandom % 14 == 0) begin bo = 1'b1; holdLen = $urandom % 5; end
    if (forceLen == 0 && !bo) longRun = 0;
    rd = (active && !firstCyc) ? ($urandom % 2 == 0) : ($urandom % 3 == 0);
    // R10: backoff on the same edge as the last burst beat
    if (!quiet && rd && !bo && active && !firstCyc && oBurst && beatIdx == NB - 1 && $urandom % 4 == 0) begin
      bo = 1'b1; hitLast++;
    end
    d = active ? beatData(oAddr, beatIdx, attempt) : DW'($urandom);
    if (!noNew && !outstanding && !reqValid && $urandom % 3 != 0) begin
      reqValid = 1'b1;
      reqWrite = ($urandom % 3 == 0);
      reqBurst = ($urandom % 2 == 0);
      reqAddr  = AW'($urandom) & ~AW'(3);
      reqWdata = DW'($urandom);
    end
    backoffIn = bo; rdyIn = rd; busDataIn = d;
    #1;
    // R13
    if (bo || outstanding) chk(!reqReady, "R13", "reqReady low when busy or backed off", LW'(reqReady), '0);
    acc = reqValid && reqReady;
    if (acc) begin
      outstanding = 1; oAddr = reqAddr; oWrite = reqWrite; oWdata = reqWdata;
      oBurst = reqBurst && !reqWrite; nBeats = oBurst ? NB : 1; accepts++;
    end
    // what the edge will do
    if (bo) begin
      if (active) begin active = 0; sinceEnd = 0; heldAds = firstCyc; end
      else if (!boffLast) heldAds = 0;
    end else begin
      heldAds = 0;
      if (active && !firstCyc && rd) begin
        if (!oWrite) expLine[beatIdx*DW +: DW] = d;
        beatIdx++;
        if (beatIdx == nBeats) begin
          active = 0; outstanding = 0; expRsp = 1; rspLine = expLine; sinceEnd = 0;
        end
      end
    end
    firstCyc = 0;
    boffPrev = boffLast; boffLast = bo; accLast = acc;

    @(negedge clk);
    // check section
    sinceEnd++;
    adsNow = adsOut && adsOe;
    if (boffLast) begin
      chk(!busAddrOe && !adsOe && !busDataOe, longRun ? "R6" : "R1", "bus floated while backed off",
          LW'({busAddrOe, adsOe, busDataOe}), '0);
      chk(adsOut == heldAds, "R8", "strobe level while backed off", LW'(adsOut), LW'(heldAds));
      chk(busReqOut == (outstanding || reqValid), "R7", "bus request while backed off",
          LW'(busReqOut), LW'(outstanding || reqValid));
    end else begin
      expAds = accLast || (boffPrev && outstanding);
      chk(adsNow == expAds, "R4", "strobe placement after accept or release", LW'(adsNow), LW'(expAds));
      if (adsNow) begin
        chk(sinceEnd >= 2, "R5", "idle clock before strobe", LW'(sinceEnd), LW'(2));
        chk(busAddr == oAddr && busWrite == oWrite, "R4", "strobe address and type",
            LW'({busWrite, busAddr}), LW'({oWrite, oAddr}));
        attempt++; active = 1; firstCyc = 1; beatIdx = 0; expLine = '0;
      end
      if (active && oWrite)
        chk(busDataOe && busWdata == oWdata, "R9", "write data driven",
            LW'({busDataOe, busWdata}), LW'({1'b1, oWdata}));
      if (active) chk(busReqOut, "R7", "bus request while owning bus", LW'(busReqOut), LW'(1));
    end
    if (expRsp) begin
      chk(rspValid, "R3", "response pulse", LW'(rspValid), LW'(1));
      chk(rspData == rspLine, "R2", "response line from final attempt (R12 beat count)", rspData, rspLine);
      expRsp = 0; rsps++;
    end else begin
      chk(!rspValid, "R3", "no stray response", LW'(rspValid), '0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11
    chk(!busAddrOe && !adsOe && !busDataOe, "R11", "enables low in reset",
        LW'({busAddrOe, adsOe, busDataOe}), '0);
    chk(!busReqOut && !rspValid, "R11", "request and response low in reset",
        LW'({busReqOut, rspValid}), '0);
    chk(reqReady, "R11", "ready in reset idle", LW'(reqReady), LW'(1));
    rst = 1'b0;
    for (int i = 0; i < 12000; i++) step();
    armLong = 1;                         // R6 long hold
    for (int i = 0; i < 8000; i++) step();
    noNew = 1; quiet = 1;
    for (int i = 0; i < 400 && (outstanding || reqValid || forceLen > 0); i++) step();
    for (int i = 0; i < 5; i++) step();
    chk(accepts == rsps, "R9", "every accepted request completed", LW'(rsps), LW'(accepts));
    chk(hitAds > 0, "R8", "backoff on strobe cycle exercised", LW'(hitAds > 0), LW'(1));
    chk(hitLast > 0, "R10", "backoff with last ready exercised", LW'(hitLast > 0), LW'(1));
    chk(hitLong > 0, "R6", "long hold exercised", LW'(hitLong > 0), LW'(1));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule